// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between a clock generator's dividers and its output pins. It decides which groups of output clocks toggle and which are held low. Three asynchronous active-low requests drive it. A CPU-stop request silences the processor-class group and the 66 MHz-class group. A PCI-stop request silences the gated PCI group and leaves the free-running PCI clock alone. A power-down request silences every group, including the free-running PCI, reference and USB clocks, and then turns off the oscillator and VCO enables. While power-down is active, the two stop requests have no effect.

The free-running PCI source clock samples the requests, so stop and start latency is counted in its rising edges. Each output group has its own enable register, loaded on the falling edge of that group's source clock. A group therefore stops only after a complete high phase and restarts only at a true rising edge. A timer clock that keeps running through power-down drives the power sequencer. On entry, the sequencer waits until the gating is confirmed before it drops the enables. On exit, it raises both enables and waits a parameterised settle count, 3 ms by default, before the clocks come back.

The group clocks are assumed to come from the same PLL as the PCI clock, and each is at least as fast as that clock. The reference and USB clocks are gated only by power-down, which is a quasi-static condition. The block has no data stream, so it has no valid/ready interface and no back-pressure rules. All its pins are plain control and clock pins.

Top module: `clkstop_ctrl`

## Requirements
- R1: While the CPU-stop request is low, every output of the CPU group and the 66 MHz group is held low. The half-rate, APIC, reference, USB, free-running PCI and gated PCI outputs keep toggling.
- R2: While the PCI-stop request is low, every gated PCI output is held low. The free-running PCI output and all other groups keep toggling.
- R3: The two stop requests act independently. When both are low, the CPU, 66 MHz and gated PCI groups are held low together, and releasing one of them restarts only its own groups.
- R4: A gated output changes only together with its source clock: it never rises or falls while the source clock is high. A stopped output stays static low.
- R5: A stop or start request takes effect at the SYNC_STAGES-th rising edge of the free-running PCI clock after the request changes. Each affected group then changes state at its own next falling edge. With SYNC_STAGES = 2, the CPU group toggles between the first and second such edges, and the gated PCI group shows its last pulse starting at the second edge.
- R6: While the power-down request is low, every output is held low, including the free-running PCI, reference and USB outputs. The free-running PCI output shows no rising edge after the third PCI edge that follows the request. The oscillator and VCO enables drop only after the timer domain has seen the gating confirmed. Toggling the stop requests during power-down changes nothing.
- R7: When the power-down request returns high, the oscillator and VCO enables rise after SYNC_STAGES timer edges. All outputs stay low for SETTLE_CYCLES further timer cycles, and then the clocks restart through the PCI-side synchroniser.
- R8: If the power-down request goes low again during the settle wait, both enables drop again and the outputs stay low. A later release starts a full new settle wait.
- R9: After reset, every group toggles and both the oscillator and VCO enables are high.
- R10: A CPU-stop request held through a complete power-down and exit keeps the CPU and 66 MHz groups low after the restart, while every other group resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| cpu_ck_i | input | 1 | CPU-group source clock |
| m66_ck_i | input | 1 | 66 MHz-group source clock |
| half_ck_i | input | 1 | Half-rate memory-reference source clock |
| apic_ck_i | input | 1 | APIC source clock |
| ref_ck_i | input | 1 | Crystal reference source clock |
| usb_ck_i | input | 1 | USB source clock |
| pcif_ck_i | input | 1 | Free-running PCI source clock; also samples the requests |
| tmr_ck_i | input | 1 | Always-on timer clock for the power sequencer |
| cpu_stop_req_n | input | 1 | Asynchronous CPU-stop request, active low |
| pci_stop_req_n | input | 1 | Asynchronous PCI-stop request, active low |
| pwrdn_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_ck_o | output | N_CPU | Gated CPU clocks |
| m66_ck_o | output | N_M66 | Gated 66 MHz-class clocks |
| half_ck_o | output | N_HALF | Gated half-rate clocks |
| apic_ck_o | output | N_APIC | Gated APIC clocks |
| ref_ck_o | output | N_REF | Gated reference clocks |
| usb_ck_o | output | 1 | Gated USB clock |
| pcif_ck_o | output | 1 | Free-running PCI output (gated by power-down only) |
| pci_ck_o | output | N_PCI | Gated PCI clocks |
| osc_en_o | output | 1 | Oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
Two controls can act in the same cycle: the PCI-side stop flag for a group and the power-down gating flag. Both feed the same falling-edge enable register. The bench holds a CPU-stop request low, starts a power-down, releases it, and then checks that after the settle wait only the CPU and 66 MHz groups stay silent. It also re-asserts power-down inside the settle window, so that the sequencer's exit path and the new entry meet. The bench judges each outcome from the toggle activity of every group over a sampling window, and from the level of the two enables at the end of that window.

// File: rtl/ckctl_pkg.sv
`timescale 1ns/1ps
package ckctl_pkg;
  // Power sequencer states
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,  // clocks running, enables on
    PS_DRAIN  = 2'd1,  // waiting for the gating to be confirmed
    PS_OFF    = 2'd2,  // oscillator and VCO off
    PS_SETTLE = 2'd3   // enables on, counting the settle time
  } pwr_state_e;
endpackage

// File: rtl/ckctl_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser with a selectable reset value.
module ckctl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= RST_VAL;
        else        sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ckctl_gate.sv
`timescale 1ns/1ps
// Glitch-free gate for one clock group: the enable is captured on the
// source falling edge, so it only changes while the source is low.
module ckctl_gate #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         allow,
  output logic [W-1:0] gck
);
  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= allow;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_copy
      assign gck[i] = clk & en_q;
    end
  endgenerate
endmodule

// File: rtl/ckctl_pwr_seq.sv
`timescale 1ns/1ps
// Power-down sequencer on the always-on timer clock.
module ckctl_pwr_seq
  import ckctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYCLES = 42955
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,    // asynchronous, active high
  input  logic stop_ack,  // gating confirmed, from the PCI domain
  output logic osc_en,
  output logic vco_en,
  output logic settled
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic pd_s, ack_s;
  pwr_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
    .clk(clk), .rst_n(rst_n), .d(pd_req), .q(pd_s));
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d(stop_ack), .q(ack_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PS_RUN:    if (pd_s) state_q <= PS_DRAIN;
        PS_DRAIN:  if (ack_s) state_q <= PS_OFF;
        PS_OFF: begin
          if (!pd_s) begin
            state_q <= PS_SETTLE;
            cnt_q   <= '0;
          end
        end
        PS_SETTLE: begin
          if (pd_s)                  state_q <= PS_OFF;
          else if (cnt_q == CNT_LAST) state_q <= PS_RUN;
          else                       cnt_q   <= cnt_q + CNT_W'(1);
        end
        default:   state_q <= PS_RUN;
      endcase
    end
  end

  assign osc_en  = (state_q != PS_OFF);
  assign vco_en  = (state_q != PS_OFF);
  assign settled = (state_q == PS_RUN);

  // R7: the clocks are released only after a full settle count
  assert_settle_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> ($past(cnt_q) == CNT_LAST && $past(vco_en)));

  // R8: a power-down request seen during settling turns the enables off next
  assert_resettle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SETTLE && pd_s) |=> !osc_en);
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
// Clock stop and power-down controller (top).
module clkstop_ctrl #(
  parameter int unsigned N_CPU         = 4,
  parameter int unsigned N_M66         = 4,
  parameter int unsigned N_HALF        = 2,
  parameter int unsigned N_APIC        = 3,
  parameter int unsigned N_REF         = 2,
  parameter int unsigned N_PCI         = 7,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYCLES = 42955
) (
  input  logic              rst_n,
  input  logic              cpu_ck_i,
  input  logic              m66_ck_i,
  input  logic              half_ck_i,
  input  logic              apic_ck_i,
  input  logic              ref_ck_i,
  input  logic              usb_ck_i,
  input  logic              pcif_ck_i,
  input  logic              tmr_ck_i,
  input  logic              cpu_stop_req_n,
  input  logic              pci_stop_req_n,
  input  logic              pwrdn_req_n,
  output logic [N_CPU-1:0]  cpu_ck_o,
  output logic [N_M66-1:0]  m66_ck_o,
  output logic [N_HALF-1:0] half_ck_o,
  output logic [N_APIC-1:0] apic_ck_o,
  output logic [N_REF-1:0]  ref_ck_o,
  output logic              usb_ck_o,
  output logic              pcif_ck_o,
  output logic [N_PCI-1:0]  pci_ck_o,
  output logic              osc_en_o,
  output logic              vco_en_o
);
  logic cpu_stop_p, pci_stop_p, pd_p, settled_p, settled_t;
  logic all_stop_p, ack_q;
  logic cpu_allow, pci_allow, free_allow;

  // Request synchronisers on the free-running PCI clock
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cpu (
    .clk(pcif_ck_i), .rst_n(rst_n), .d(~cpu_stop_req_n), .q(cpu_stop_p));
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pci (
    .clk(pcif_ck_i), .rst_n(rst_n), .d(~pci_stop_req_n), .q(pci_stop_p));
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
    .clk(pcif_ck_i), .rst_n(rst_n), .d(~pwrdn_req_n), .q(pd_p));
  ckctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_settled (
    .clk(pcif_ck_i), .rst_n(rst_n), .d(settled_t), .q(settled_p));

  assign all_stop_p = pd_p | ~settled_p;
  assign cpu_allow  = ~(cpu_stop_p | all_stop_p);
  assign pci_allow  = ~(pci_stop_p | all_stop_p);
  assign free_allow = ~all_stop_p;

  // Registered confirmation of the gating, handed to the timer domain
  always_ff @(posedge pcif_ck_i or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= all_stop_p;
  end

  ckctl_pwr_seq #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk(tmr_ck_i), .rst_n(rst_n), .pd_req(~pwrdn_req_n), .stop_ack(ack_q),
    .osc_en(osc_en_o), .vco_en(vco_en_o), .settled(settled_t));

  // Group gates
  ckctl_gate #(.W(N_CPU))  u_g_cpu  (.clk(cpu_ck_i),  .rst_n(rst_n), .allow(cpu_allow),  .gck(cpu_ck_o));
  ckctl_gate #(.W(N_M66))  u_g_m66  (.clk(m66_ck_i),  .rst_n(rst_n), .allow(cpu_allow),  .gck(m66_ck_o));
  ckctl_gate #(.W(N_HALF)) u_g_half (.clk(half_ck_i), .rst_n(rst_n), .allow(free_allow), .gck(half_ck_o));
  ckctl_gate #(.W(N_APIC)) u_g_apic (.clk(apic_ck_i), .rst_n(rst_n), .allow(free_allow), .gck(apic_ck_o));
  ckctl_gate #(.W(N_REF))  u_g_ref  (.clk(ref_ck_i),  .rst_n(rst_n), .allow(free_allow), .gck(ref_ck_o));
  ckctl_gate #(.W(1))      u_g_usb  (.clk(usb_ck_i),  .rst_n(rst_n), .allow(free_allow), .gck(usb_ck_o));
  ckctl_gate #(.W(1))      u_g_pcif (.clk(pcif_ck_i), .rst_n(rst_n), .allow(free_allow), .gck(pcif_ck_o));
  ckctl_gate #(.W(N_PCI))  u_g_pci  (.clk(pcif_ck_i), .rst_n(rst_n), .allow(pci_allow),  .gck(pci_ck_o));

  // R1: a CPU stop seen over two PCI edges has closed the CPU gate
  assert_cpu_held_R1: assert property (@(posedge pcif_ck_i) disable iff (!rst_n)
    (cpu_stop_p && $past(cpu_stop_p)) |-> !u_g_cpu.en_q);

  // R1: a CPU stop never closes the half-rate gate
  assert_half_free_R1: assert property (@(posedge pcif_ck_i) disable iff (!rst_n)
    (!all_stop_p && $past(!all_stop_p)) |-> u_g_half.en_q);

  // R2: a PCI stop has closed the gated PCI group
  assert_pci_held_R2: assert property (@(posedge pcif_ck_i) disable iff (!rst_n)
    (pci_stop_p && $past(pci_stop_p)) |-> !u_g_pci.en_q);

  // R2: the free-running output stays open outside power-down
  assert_pcif_free_R2: assert property (@(posedge pcif_ck_i) disable iff (!rst_n)
    (!all_stop_p && $past(!all_stop_p)) |-> u_g_pcif.en_q);

  // R6: power-down closes the free-running output as well
  assert_pd_gates_R6: assert property (@(posedge pcif_ck_i) disable iff (!rst_n)
    (all_stop_p && $past(all_stop_p)) |-> !u_g_pcif.en_q);

  // R6: the VCO goes off only while the outputs are gated
  assert_vco_after_gate_R6: assert property (@(posedge tmr_ck_i) disable iff (!rst_n)
    $fell(vco_en_o) |-> all_stop_p);
endmodule

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/100ps
module tb_clkstop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;
  localparam int NSYNC      = 2;

  // activity bit order
  localparam logic [7:0] M_CPU  = 8'h01;
  localparam logic [7:0] M_M66  = 8'h02;
  localparam logic [7:0] M_HALF = 8'h04;
  localparam logic [7:0] M_APIC = 8'h08;
  localparam logic [7:0] M_REF  = 8'h10;
  localparam logic [7:0] M_USB  = 8'h20;
  localparam logic [7:0] M_PCIF = 8'h40;
  localparam logic [7:0] M_PCI  = 8'h80;
  localparam logic [7:0] M_ALL  = 8'hFF;

  logic rst_n = 1'b0;
  logic cpu_src = 1'b0, m66_src = 1'b1, half_src = 1'b0, apic_src = 1'b0;
  logic pci_src = 1'b0, ref_src = 1'b0, usb_src = 1'b0, tmr_src = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;

  logic [3:0] cpu_o;
  logic [3:0] m66_o;
  logic [1:0] half_o;
  logic [2:0] apic_o;
  logic [1:0] ref_o;
  logic       usb_o, pcif_o;
  logic [6:0] pci_o;
  logic       osc_en, vco_en;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit done = 0;

  clkstop_ctrl #(.SYNC_STAGES(NSYNC), .SETTLE_CYCLES(SETTLE)) dut (
    .rst_n(rst_n), .cpu_ck_i(cpu_src), .m66_ck_i(m66_src), .half_ck_i(half_src),
    .apic_ck_i(apic_src), .ref_ck_i(ref_src), .usb_ck_i(usb_src),
    .pcif_ck_i(pci_src), .tmr_ck_i(tmr_src),
    .cpu_stop_req_n(cpu_stop_n), .pci_stop_req_n(pci_stop_n), .pwrdn_req_n(pwrdn_n),
    .cpu_ck_o(cpu_o), .m66_ck_o(m66_o), .half_ck_o(half_o), .apic_ck_o(apic_o),
    .ref_ck_o(ref_o), .usb_ck_o(usb_o), .pcif_ck_o(pcif_o), .pci_ck_o(pci_o),
    .osc_en_o(osc_en), .vco_en_o(vco_en));

  // Clock sources: PLL-derived groups divided from the CPU clock
  always #(CLK_PERIOD/2) cpu_src = ~cpu_src;
  int unsigned div_cnt = 0;
  always @(posedge cpu_src) begin
    div_cnt  <= div_cnt + 1;
    half_src <= ~half_src;
    m66_src  <= ~m66_src;
    if (div_cnt[0])        pci_src  <= ~pci_src;
    if (div_cnt[1:0] == 3) apic_src <= ~apic_src;
  end
  always #35 ref_src = ~ref_src;
  always #11 usb_src = ~usb_src;
  always #25 tmr_src = ~tmr_src;

  // Scoreboard
  typedef struct {
    string      req;
    logic [7:0] care;
    logic [7:0] exp_act;
    int         win;
    bit         chk_en;
    logic       exp_osc;
  } exp_t;
  exp_t exp_q[$];
  bit busy = 0;

  task automatic expect_act(input string req, input logic [7:0] care,
                            input logic [7:0] exp_act, input int win,
                            input bit chk_en, input logic exp_osc);
    exp_t it;
    it.req = req; it.care = care; it.exp_act = exp_act; it.win = win;
    it.chk_en = chk_en; it.exp_osc = exp_osc;
    busy = 1;
    exp_q.push_back(it);
    wait (busy == 0);
  endtask

  // Monitor: pops an expectation, observes toggle activity, compares
  initial begin
    forever begin
      exp_t it;
      logic [7:0] act;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      act = '0;
      #0.5;
      for (int i = 0; i < it.win; i++) begin
        act |= {|pci_o, pcif_o, usb_o, |ref_o, |apic_o, |half_o, |m66_o, |cpu_o};
        #1;
      end
      checks++;
      if ((act & it.care) !== (it.exp_act & it.care)) begin
        errors++;
        $display("FAIL %s: activity %b expected %b (care %b)", it.req,
                 act & it.care, it.exp_act & it.care, it.care);
      end
      if (it.chk_en) begin
        checks++;
        if (osc_en !== it.exp_osc || vco_en !== it.exp_osc) begin
          errors++;
          $display("FAIL %s: osc_en %b vco_en %b expected %b", it.req,
                   osc_en, vco_en, it.exp_osc);
        end
      end
      #0.5;
      busy = 0;
    end
  end

  // Glitch sampler (R4): outputs may move only with their source clock
  initial begin
    logic [3:0] go, gs, pgo, pgs;
    pgo = '0; pgs = '0;
    #0.5;
    forever begin
      go = {usb_o, half_o[0], pci_o[0], cpu_o[0]};
      gs = {usb_src, half_src, pci_src, cpu_src};
      if (rst_n) begin
        for (int i = 0; i < 4; i++) begin
          if ((go[i] && !pgo[i] && pgs[i]) || (!go[i] && pgo[i] && gs[i]))
            glitches++;
        end
      end
      pgo = go; pgs = gs;
      #1;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    #103 rst_n = 1'b1;
    #200;
    // R9: reset state
    expect_act("R9 reset all running", M_ALL, M_ALL, 200, 1, 1'b1);

    // R1: CPU stop
    cpu_stop_n = 1'b0; #300;
    expect_act("R1 cpu stop", M_ALL, M_ALL & ~(M_CPU | M_M66), 200, 1, 1'b1);
    // R3: both stops together
    pci_stop_n = 1'b0; #300;
    expect_act("R3 both stops", M_ALL, M_ALL & ~(M_CPU | M_M66 | M_PCI), 200, 0, 1'b1);
    // R3/R2: release CPU only; PCI stop remains
    cpu_stop_n = 1'b1; #300;
    expect_act("R2 pci stop only", M_ALL, M_ALL & ~M_PCI, 200, 0, 1'b1);
    pci_stop_n = 1'b1; #300;
    expect_act("R3 all released", M_ALL, M_ALL, 200, 0, 1'b1);

    // R5: CPU stop latency
    @(posedge pci_src); #1 cpu_stop_n = 1'b0;
    @(posedge pci_src); #1;
    expect_act("R5 cpu runs before sync edge", M_CPU, M_CPU, 30, 0, 1'b1);
    @(posedge pci_src); #6;
    expect_act("R5 cpu held after sync edge", M_CPU, 8'h00, 60, 0, 1'b1);
    // R5: CPU start latency
    @(posedge pci_src); #1 cpu_stop_n = 1'b1;
    @(posedge pci_src); #1;
    expect_act("R5 cpu held before restart edge", M_CPU, 8'h00, 30, 0, 1'b1);
    @(posedge pci_src); #6;
    expect_act("R5 cpu restarts", M_CPU, M_CPU, 60, 0, 1'b1);

    // R5: PCI stop latency
    @(posedge pci_src); #1 pci_stop_n = 1'b0;
    @(posedge pci_src); #1;
    expect_act("R5 pci runs before sync edge", M_PCI, M_PCI, 30, 0, 1'b1);
    @(posedge pci_src); @(posedge pci_src); #1;
    expect_act("R5 pci held, pcif free", M_PCI | M_PCIF, M_PCIF, 60, 0, 1'b1);
    @(posedge pci_src); #1 pci_stop_n = 1'b1;
    @(posedge pci_src); #1;
    expect_act("R5 pci held before restart", M_PCI, 8'h00, 30, 0, 1'b1);
    @(posedge pci_src); #1;
    expect_act("R5 pci restarts", M_PCI, M_PCI, 60, 0, 1'b1);

    // R6: power-down entry latency and full gating
    @(posedge pci_src); #1 pwrdn_n = 1'b0;
    @(posedge pci_src); #1;
    expect_act("R6 pcif runs before sync edge", M_PCIF, M_PCIF, 30, 0, 1'b1);
    @(posedge pci_src); @(posedge pci_src); #1;
    expect_act("R6 pcif and cpu gated", M_PCIF | M_CPU | M_PCI, 8'h00, 60, 0, 1'b1);
    #500;
    expect_act("R6 power-down all low, enables off", M_ALL, 8'h00, 200, 1, 1'b0);
    // R6: stops are don't-care in power-down
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0; #200;
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; #100;
    expect_act("R6 stops ignored in power-down", M_ALL, 8'h00, 200, 1, 1'b0);

    // R7: exit with settle wait
    pwrdn_n = 1'b1; #300;
    expect_act("R7 settling, enables on, outputs low", M_ALL, 8'h00, 200, 1, 1'b1);
    #1100;
    expect_act("R7 clocks restarted", M_ALL, M_ALL, 200, 1, 1'b1);

    // R8: re-entry during settle
    pwrdn_n = 1'b0; #500;
    pwrdn_n = 1'b1; #400;
    pwrdn_n = 1'b0; #500;
    expect_act("R8 re-entry during settle", M_ALL, 8'h00, 200, 1, 1'b0);
    pwrdn_n = 1'b1; #1600;
    expect_act("R8 restart after new settle", M_ALL, M_ALL, 200, 1, 1'b1);

    // R10: CPU stop held across power-down
    cpu_stop_n = 1'b0; #300;
    pwrdn_n = 1'b0; #500;
    pwrdn_n = 1'b1; #1600;
    expect_act("R10 cpu stop kept after exit", M_ALL, M_ALL & ~(M_CPU | M_M66), 200, 1, 1'b1);
    cpu_stop_n = 1'b1; #300;
    expect_act("R10 all running after release", M_ALL, M_ALL, 200, 0, 1'b1);

    // R4: glitch-free gating over the whole run
    checks++;
    if (glitches != 0) begin
      errors++;
      $display("FAIL R4 glitch count: actual %0d expected 0", glitches);
    end
    finish_run();
  end
endmodule